// File: doc/BRIEF.md
# DRAM Bank Command Sequencer

This block serves read and write requests aimed at a single DRAM bank. Each request carries a full address made of a row part and a column part. The block turns each request into the bank command steps the request needs: open a row, access a column, and close the row. The row number and the column number share one address bus and are driven at different times. The row number goes out with the open command, and the column number goes out later with the read or write command.

The sequencer keeps the last opened row open. A later request to that same row goes straight to column access. A request to a different row first closes the open row, then opens the new one. Three parameters set the minimum spacing between these steps: close-to-open, open-to-column, and column-to-data. A single down-counter enforces them.

A compact bank model sits behind the command bus. It holds the row array and a sense latch as wide as one row. An open command copies a row into the latch. A column write changes one data-wide slice of the latch. A close command writes the latch back into the array. A column read takes one slice out of the latch. Requests use a valid/ready handshake. Read data comes back with a one-cycle valid pulse.

Top module: `dram_bank_seq`

## Requirements
- R1: During and after reset, `req_ready` is 1, `bank_cmd` is NOP (0) and `rsp_valid` is 0. No row is open, so the first request after reset never produces a close command.
- R2: `bank_cmd` is encoded as 0 = NOP, 1 = open row, 2 = column read, 3 = column write, 4 = close row. `bank_addr` carries the row number with an open command and the zero-extended column number with a read or write command. It is 0 in every other cycle.
- R3: `req_addr` holds the row in its upper ROW_W bits and the column in its lower COL_W bits. A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` stays 0 from that edge until the request completes.
- R4: When no row is open, the open command appears in the first cycle after acceptance. The column command follows T_RCD cycles later.
- R5: When the requested row is the open row, the column command appears in the first cycle after acceptance. No open or close command is issued for that request.
- R6: When a different row is open, the close command appears in the first cycle after acceptance. The open command follows T_RP cycles later, and the column command follows T_RCD cycles after the open command.
- R7: For a read, `rsp_valid` is high for exactly one cycle, T_CL cycles after the column command. In that cycle `rsp_rdata` holds the addressed slice and `req_ready` returns to 1.
- R8: A write replaces only the DATA_W-bit slice at column c, which is bits c*DATA_W upward of the row. Other slices of the row are unchanged. A write never raises `rsp_valid`, and `req_ready` returns T_CL cycles after the write command.
- R9: Data written to a row is still there after that row has been closed and opened again.
- R10: Between two commands, and whenever no request is in progress, `bank_cmd` is NOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+COL_W | Row in upper bits, column in lower bits |
| req_wdata | input | DATA_W | Write data for one column slice |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | DATA_W | Read data |
| bank_cmd | output | 3 | Command issued this cycle |
| bank_addr | output | AW | Multiplexed row/column address |

## Verification
Three kinds of sweep are used. The first writes every row/column cell in row-major order, so each row's first access opens a row and the other accesses in that row hit it. The second reads every cell back in column-major order, so every request changes row and has to take the close-then-open path; wrong data here shows that write-back on close is faulty. In the third, one slice of an open row is overwritten and its neighbours are read as row hits, together with repeated reads of the same cell. This shows whether the slice mask and the short hit path are right. For every request, the bench checks the exact cycle of each command against the timing parameters and rejects any command in the gaps between them.

// File: rtl/dram_bank_seq_pkg.sv
package dram_bank_seq_pkg;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4
    } bank_cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_PRE_WAIT = 2'd1,
        ST_ACT_WAIT = 2'd2,
        ST_COL_WAIT = 2'd3
    } seq_state_e;

endpackage

// File: rtl/dram_bank_seq_timer.sv
module dram_bank_seq_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             expire_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expire_o = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/dram_bank_seq_array.sv
module dram_bank_seq_array
    import dram_bank_seq_pkg::*;
#(
    parameter int NUM_ROWS = 8,
    parameter int COLS     = 4,
    parameter int DATA_W   = 8,
    parameter int AW       = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bank_cmd_e         cmd_i,
    input  logic [AW-1:0]     addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o
);
    localparam int ROW_BITS = COLS * DATA_W;

    logic [ROW_BITS-1:0] mem_d   [NUM_ROWS];
    logic [ROW_BITS-1:0] mem_q   [NUM_ROWS];
    logic [ROW_BITS-1:0] sense_d, sense_q;
    logic [AW-1:0]       act_row_d, act_row_q;
    logic                act_vld_d, act_vld_q;
    logic [DATA_W-1:0]   rdata_d, rdata_q;
    logic [ROW_BITS-1:0] slice_mask;
    int                  shift;

    always_comb begin
        shift      = int'(addr_i) * DATA_W;
        slice_mask = ROW_BITS'({DATA_W{1'b1}}) << shift;
        mem_d      = mem_q;
        sense_d    = sense_q;
        act_row_d  = act_row_q;
        act_vld_d  = act_vld_q;
        rdata_d    = rdata_q;
        case (cmd_i)
            CMD_ACT: begin
                sense_d   = mem_q[addr_i];
                act_row_d = addr_i;
                act_vld_d = 1'b1;
            end
            CMD_RD: begin
                rdata_d = DATA_W'(sense_q >> shift);
            end
            CMD_WR: begin
                sense_d = (sense_q & ~slice_mask) | (ROW_BITS'(wdata_i) << shift);
            end
            CMD_PRE: begin
                mem_d[act_row_q] = sense_q;
                act_vld_d        = 1'b0;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < NUM_ROWS; r++) begin
                mem_q[r] <= '0;
            end
            sense_q   <= '0;
            act_row_q <= '0;
            act_vld_q <= 1'b0;
            rdata_q   <= '0;
        end else begin
            mem_q     <= mem_d;
            sense_q   <= sense_d;
            act_row_q <= act_row_d;
            act_vld_q <= act_vld_d;
            rdata_q   <= rdata_d;
        end
    end

    assign rdata_o = rdata_q;

    // R5
    col_needs_open_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_RD || cmd_i == CMD_WR) |-> act_vld_q);

    // R6
    open_needs_closed_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_ACT) |-> !act_vld_q);

endmodule

// File: rtl/dram_bank_seq.sv
module dram_bank_seq
    import dram_bank_seq_pkg::*;
#(
    parameter int NUM_ROWS = 8,
    parameter int COLS     = 4,
    parameter int DATA_W   = 8,
    parameter int T_RP     = 2,
    parameter int T_RCD    = 3,
    parameter int T_CL     = 2,
    localparam int ROW_W   = $clog2(NUM_ROWS),
    localparam int COL_W   = $clog2(COLS),
    localparam int AW      = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic                   req_write,
    input  logic [ROW_W+COL_W-1:0] req_addr,
    input  logic [DATA_W-1:0]      req_wdata,
    output logic                   rsp_valid,
    output logic [DATA_W-1:0]      rsp_rdata,
    output logic [2:0]             bank_cmd,
    output logic [AW-1:0]          bank_addr
);
    localparam int T_MAX = (T_RP > T_RCD) ? ((T_RP > T_CL) ? T_RP : T_CL)
                                          : ((T_RCD > T_CL) ? T_RCD : T_CL);
    localparam int CNT_W = $clog2(T_MAX + 1);

    typedef struct packed {
        seq_state_e         st;
        bank_cmd_e          cmd;
        logic [AW-1:0]      addr;
        logic               open_vld;
        logic [ROW_W-1:0]   open_row;
        logic               wr;
        logic [ROW_W-1:0]   row;
        logic [COL_W-1:0]   col;
        logic [DATA_W-1:0]  wdata;
        logic               rsp_vld;
    } seq_t;

    seq_t             s_d, s_q;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expire;
    logic [ROW_W-1:0] in_row;
    logic [COL_W-1:0] in_col;

    assign in_row = req_addr[ROW_W+COL_W-1:COL_W];
    assign in_col = req_addr[COL_W-1:0];

    always_comb begin
        s_d         = s_q;
        s_d.cmd     = CMD_NOP;
        s_d.addr    = '0;
        s_d.rsp_vld = 1'b0;
        tmr_load    = 1'b0;
        tmr_val     = '0;
        case (s_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    s_d.wr    = req_write;
                    s_d.row   = in_row;
                    s_d.col   = in_col;
                    s_d.wdata = req_wdata;
                    tmr_load  = 1'b1;
                    if (s_q.open_vld && (s_q.open_row == in_row)) begin
                        s_d.cmd  = req_write ? CMD_WR : CMD_RD;
                        s_d.addr = AW'(in_col);
                        s_d.st   = ST_COL_WAIT;
                        tmr_val  = CNT_W'(T_CL);
                    end else if (s_q.open_vld) begin
                        s_d.cmd      = CMD_PRE;
                        s_d.open_vld = 1'b0;
                        s_d.st       = ST_PRE_WAIT;
                        tmr_val      = CNT_W'(T_RP);
                    end else begin
                        s_d.cmd      = CMD_ACT;
                        s_d.addr     = AW'(in_row);
                        s_d.open_vld = 1'b1;
                        s_d.open_row = in_row;
                        s_d.st       = ST_ACT_WAIT;
                        tmr_val      = CNT_W'(T_RCD);
                    end
                end
            end
            ST_PRE_WAIT: begin
                if (tmr_expire) begin
                    s_d.cmd      = CMD_ACT;
                    s_d.addr     = AW'(s_q.row);
                    s_d.open_vld = 1'b1;
                    s_d.open_row = s_q.row;
                    s_d.st       = ST_ACT_WAIT;
                    tmr_load     = 1'b1;
                    tmr_val      = CNT_W'(T_RCD);
                end
            end
            ST_ACT_WAIT: begin
                if (tmr_expire) begin
                    s_d.cmd  = s_q.wr ? CMD_WR : CMD_RD;
                    s_d.addr = AW'(s_q.col);
                    s_d.st   = ST_COL_WAIT;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(T_CL);
                end
            end
            ST_COL_WAIT: begin
                if (tmr_expire) begin
                    s_d.st      = ST_IDLE;
                    s_d.rsp_vld = !s_q.wr;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, cmd: CMD_NOP, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    dram_bank_seq_timer #(.CNT_W(CNT_W)) timer_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .expire_o   (tmr_expire)
    );

    dram_bank_seq_array #(
        .NUM_ROWS (NUM_ROWS),
        .COLS     (COLS),
        .DATA_W   (DATA_W),
        .AW       (AW)
    ) array_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd_i   (s_q.cmd),
        .addr_i  (s_q.addr),
        .wdata_i (s_q.wdata),
        .rdata_o (rsp_rdata)
    );

    assign req_ready = (s_q.st == ST_IDLE);
    assign rsp_valid = s_q.rsp_vld;
    assign bank_cmd  = s_q.cmd;
    assign bank_addr = s_q.addr;

    // R7
    rsp_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R7
    ready_with_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> req_ready);

    // R3
    accept_issues_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (bank_cmd != 3'(CMD_NOP)));

    // R10
    open_then_no_row_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_cmd == 3'(CMD_ACT)) |=> (bank_cmd != 3'(CMD_ACT) && bank_cmd != 3'(CMD_PRE)));

endmodule

// File: tb/dram_bank_seq_tb_top.sv
`timescale 1ns/1ps
module dram_bank_seq_tb_top;
    localparam int NR = 8, NC = 4, DW = 8;
    localparam int TP = 2, TR = 3, TC = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [4:0] req_addr = '0;
    logic [7:0] req_wdata = '0;
    logic req_ready, rsp_valid;
    logic [7:0] rsp_rdata;
    logic [2:0] bank_cmd;
    logic [2:0] bank_addr;

    int total = 0, bad = 0;
    logic [7:0] mdl [NR][NC];
    bit mdl_open = 1'b0;
    int mdl_row = 0;
    bit first_req = 1'b1;

    always #4 clk = ~clk;

    dram_bank_seq #(.NUM_ROWS(NR), .COLS(NC), .DATA_W(DW), .T_RP(TP), .T_RCD(TR), .T_CL(TC)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .bank_cmd(bank_cmd), .bank_addr(bank_addr));

    task automatic chk(bit ok, string rq, string what, int got, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, got, exp);
        end
    endtask

    function automatic logic [7:0] pat(int r, int c);
        return 8'((r * 37 + c * 11 + 3) & 255);
    endfunction

    task automatic run_req(bit wr, int row, int col, logic [7:0] wd, string dtag);
        int k_pre, k_act, k_col, k_end, exp_cmd, exp_addr, bad_k, got_c, exp_c;
        bit trace_ok, busy_ok;
        string rq;
        if (mdl_open && mdl_row == row) begin
            k_pre = -1; k_act = -1; k_col = 1; rq = "R2 R5";
        end else if (mdl_open) begin
            k_pre = 1; k_act = 1 + TP; k_col = k_act + TR; rq = "R2 R6";
        end else begin
            k_pre = -1; k_act = 1; k_col = 1 + TR; rq = first_req ? "R1 R2 R4" : "R2 R4";
        end
        k_end = k_col + TC;
        while (req_ready !== 1'b1) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_wdata = wd;
        req_addr = 5'(row * NC + col);
        @(negedge clk);
        req_valid = 1'b0;
        trace_ok = 1'b1; busy_ok = 1'b1; bad_k = 0; got_c = 0; exp_c = 0;
        for (int k = 1; k <= k_end; k++) begin
            exp_cmd  = (k == k_pre) ? 4 : (k == k_act) ? 1 : (k == k_col) ? (wr ? 3 : 2) : 0;
            exp_addr = (k == k_act) ? row : (k == k_col) ? col : 0;
            if (trace_ok && (int'(bank_cmd) != exp_cmd || int'(bank_addr) != exp_addr)) begin
                trace_ok = 1'b0; bad_k = k;
                got_c = int'(bank_cmd) * 16 + int'(bank_addr);
                exp_c = exp_cmd * 16 + exp_addr;
            end
            if (k < k_end) begin
                if (rsp_valid !== 1'b0 || req_ready !== 1'b0) busy_ok = 1'b0;
                @(negedge clk);
            end
        end
        chk(trace_ok, rq, $sformatf("cmd*16+addr at cycle %0d", bad_k), got_c, exp_c);
        chk(busy_ok, "R3", "ready/rsp low while busy", 0, 1);
        chk(req_ready === 1'b1, "R3", "ready at completion", int'(req_ready), 1);
        if (wr) begin
            chk(rsp_valid === 1'b0, "R8", "rsp_valid on write", int'(rsp_valid), 0);
            mdl[row][col] = wd;
        end else begin
            chk(rsp_valid === 1'b1 && rsp_rdata === mdl[row][col], dtag,
                "read data (valid*256+data)", int'(rsp_valid) * 256 + int'(rsp_rdata),
                256 + int'(mdl[row][col]));
        end
        mdl_open = 1'b1; mdl_row = row; first_req = 1'b0;
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL R3 watchdog: actual=%0d expected=%0d", 0, 1);
        summary();
    end

    initial begin
        for (int r = 0; r < NR; r++)
            for (int c = 0; c < NC; c++)
                mdl[r][c] = 8'h00;
        repeat (3) @(negedge clk);
        chk(req_ready === 1'b1 && bank_cmd === 3'd0 && rsp_valid === 1'b0, "R1",
            "reset outputs (ready,cmd,rsp)", int'({req_ready, bank_cmd, rsp_valid}), 16'h10);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready === 1'b1 && bank_cmd === 3'd0 && rsp_valid === 1'b0, "R1",
            "outputs after reset", int'({req_ready, bank_cmd, rsp_valid}), 16'h10);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(bank_cmd === 3'd0 && bank_addr === 3'd0, "R10", "idle bus", int'(bank_cmd), 0);
        end
        // first request: reset contents are zero, row closed
        run_req(1'b0, 2, 1, 8'h00, "R1");
        // row-major write sweep
        for (int r = 0; r < NR; r++)
            for (int c = 0; c < NC; c++)
                run_req(1'b1, r, c, pat(r, c), "R8");
        // column-major read sweep: every request changes row
        for (int c = NC - 1; c >= 0; c--)
            for (int r = 0; r < NR; r++)
                run_req(1'b0, r, c, 8'h00, "R9");
        // slice isolation within an open row
        run_req(1'b1, 3, 1, 8'hC3, "R8");
        for (int c = 0; c < NC; c++)
            run_req(1'b0, 3, c, 8'h00, "R8");
        // repeated hits on one cell
        for (int i = 0; i < 3; i++)
            run_req(1'b0, 6, 2, 8'h00, "R7");
        // reopen row 3 after leaving it
        run_req(1'b0, 3, 1, 8'h00, "R9");
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(bank_cmd === 3'd0 && rsp_valid === 1'b0, "R10", "idle after traffic",
                int'(bank_cmd), 0);
        end
        summary();
    end
endmodule